// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block works out where a 32-bit RISC core with fixed 4-byte instructions fetches next. For each operation it is given the current PC, the decoded operation, the 16-bit and 26-bit immediates, the two source operands and the three dedicated return-address registers. From these it produces the next PC, and a taken flag that marks a redirect away from the sequential address. It also produces a link-register write for calls and for reading the next PC, and a selector that tells the status logic which saved status word to restore.

Two kinds of fault are flagged here. A register-held target whose low two bits are not zero does not redirect. Instead the unit raises a misaligned-address exception and reports the offending target as the bad address. An exception or break return attempted in user mode raises a privilege exception. In both cases the next PC is the sequential address, and exception vector selection is left to the core. All results are registered and appear one cycle after the operation is presented.

Top module: `npc_unit`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with `op_valid` low, `npc_valid`, `taken`, `lnk_we` and `exc_req` are 0, and `stat_sel` and `exc_code` are 0.
- R2: Every result appears on the clock edge after `op_valid` is high. Operation code 0 (sequential) gives `npc` = `cur_pc`+4 with `taken` 0.
- R3: Operation code 1 (unconditional branch) gives `npc` = `cur_pc`+4 + sign-extended `imm16` with bits 1:0 forced to 0, and `taken` 1.
- R4: The conditional branches compare `opnd_a` with `opnd_b`. Code 2 is signed a>=b, 3 is signed a<b, 4 is a!=b, 5 is a==b, 6 is unsigned a>=b and 7 is unsigned a<b. When the condition holds, the target is the R3 target. When it fails, `npc` = `cur_pc`+4 and `taken` is 0.
- R5: Code 8 (absolute jump) gives `npc` = {`cur_pc`[31:28], `imm26`, 2'b00} with `taken` 1.
- R6: Code 9 (call) jumps like R5. It also writes `cur_pc`+4 (`lnk_we` 1, `lnk_idx` 31, `lnk_data`).
- R7: Code 10 (jump register) targets `opnd_a`. Code 12 (return) targets `reg_ra`. Code 11 (call register) targets `opnd_a` and writes `cur_pc`+4 to register 31.
- R8: For codes 10, 11 and 12, a target with bits 1:0 not zero does not redirect. `exc_req` is 1, `exc_code` is 1 (misaligned), `bad_addr` is the target, `npc` = `cur_pc`+4, `taken` is 0, and there is no link write.
- R9: In supervisor mode (`user_mode` 0), code 13 (exception return) jumps to `reg_ea` with `stat_sel` 1. Code 14 (break return) jumps to `reg_ba` with `stat_sel` 2.
- R10: With `user_mode` 1, codes 13 and 14 raise `exc_code` 2 (privilege). In that case `stat_sel` is 0, `npc` = `cur_pc`+4 and `taken` is 0.
- R11: Code 15 (read next PC) writes `cur_pc`+4 to register `dst_c` with `npc` = `cur_pc`+4. When `dst_c` is 0 the write is dropped (`lnk_we` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| cur_pc | input | 32 | Address of the current instruction |
| imm16 | input | 16 | Branch displacement |
| imm26 | input | 26 | Absolute jump word index |
| dst_c | input | 5 | Destination register for read-next-PC |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| reg_ra | input | 32 | Return-address register value |
| reg_ea | input | 32 | Exception-return address register value |
| reg_ba | input | 32 | Break-return address register value |
| user_mode | input | 1 | Core is in user mode |
| npc_valid | output | 1 | Results below are valid |
| npc | output | 32 | Next program counter |
| taken | output | 1 | Flow redirected away from PC+4 |
| lnk_we | output | 1 | Link register write request |
| lnk_idx | output | 5 | Link register index |
| lnk_data | output | 32 | Link value |
| stat_sel | output | 2 | Status restore source: 0 none, 1 exception-saved, 2 break-saved |
| exc_req | output | 1 | Exception request |
| exc_code | output | 2 | 0 none, 1 misaligned target, 2 privilege |
| bad_addr | output | 32 | Faulting target for a misaligned exception |

## Verification
The alignment assertion assumes that the current PC and the exception and break return registers always hold word-aligned values. With those inputs aligned, every redirected or sequential next PC is also aligned. The stimulus therefore misaligns only operand A and the return-address register, which are the inputs the unit itself must screen. The region assertion assumes the PC is stable only across the presenting cycle, so the bench changes the PC freely between operations. All other inputs may take any value.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        OP_SEQ    = 4'd0,
        OP_BR     = 4'd1,
        OP_BGE    = 4'd2,
        OP_BLT    = 4'd3,
        OP_BNE    = 4'd4,
        OP_BEQ    = 4'd5,
        OP_BGEU   = 4'd6,
        OP_BLTU   = 4'd7,
        OP_JABS   = 4'd8,
        OP_CALL   = 4'd9,
        OP_JREG   = 4'd10,
        OP_CALLR  = 4'd11,
        OP_RET    = 4'd12,
        OP_ERET   = 4'd13,
        OP_BRET   = 4'd14,
        OP_NEXTPC = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_ALIGN = 2'd1,
        EXC_PRIV  = 2'd2
    } exc_e;

    typedef enum logic [1:0] {
        STAT_KEEP = 2'd0,
        STAT_EXC  = 2'd1,
        STAT_BRK  = 2'd2
    } stat_e;

endpackage

// File: rtl/npc_cmp.sv
module npc_cmp
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  op_e             op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit
);
    logic eq, lt_s, lt_u;

    assign eq   = (a == b);
    assign lt_s = ($signed(a) < $signed(b));
    assign lt_u = (a < b);

    always_comb begin
        unique case (op)
            OP_BR:   hit = 1'b1;
            OP_BGE:  hit = !lt_s;
            OP_BLT:  hit = lt_s;
            OP_BNE:  hit = !eq;
            OP_BEQ:  hit = eq;
            OP_BGEU: hit = !lt_u;
            OP_BLTU: hit = lt_u;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_tgt.sv
module npc_tgt #(
    parameter int XLEN       = 32,
    parameter int IMM_W      = 16,
    parameter int JIMM_W     = 26,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [JIMM_W-1:0] imm26,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   br_pc,
    output logic [XLEN-1:0]   abs_pc
);
    localparam int REGION = XLEN - JIMM_W - 2;
    localparam int EXT    = XLEN - IMM_W;

    logic [XLEN-1:0] disp;

    // Word displacement: sign-extend, then drop the sub-word bits.
    assign disp   = {{EXT{imm16[IMM_W-1]}}, imm16[IMM_W-1:2], 2'b00};
    assign seq_pc = pc + XLEN'(INSN_BYTES);
    assign br_pc  = seq_pc + disp;
    assign abs_pc = {pc[XLEN-1 -: REGION], imm26, 2'b00};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMM_W      = 16,
    parameter int JIMM_W     = 26,
    parameter int REG_W      = 5,
    parameter int LINK_REG   = 31,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [JIMM_W-1:0] imm26,
    input  logic [REG_W-1:0]  dst_c,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [XLEN-1:0]   reg_ra,
    input  logic [XLEN-1:0]   reg_ea,
    input  logic [XLEN-1:0]   reg_ba,
    input  logic              user_mode,
    output logic              npc_valid,
    output logic [XLEN-1:0]   npc,
    output logic              taken,
    output logic              lnk_we,
    output logic [REG_W-1:0]  lnk_idx,
    output logic [XLEN-1:0]   lnk_data,
    output logic [1:0]        stat_sel,
    output logic              exc_req,
    output logic [1:0]        exc_code,
    output logic [XLEN-1:0]   bad_addr
);
    localparam int REGION = XLEN - JIMM_W - 2;
    localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

    typedef struct packed {
        logic             valid;
        logic [XLEN-1:0]  npc;
        logic             taken;
        logic             we;
        logic [REG_W-1:0] idx;
        logic [XLEN-1:0]  ldata;
        stat_e            stat;
        logic             exc;
        exc_e             code;
        logic [XLEN-1:0]  bad;
    } npc_st_t;

    op_e             op;
    logic            cond_hit;
    logic [XLEN-1:0] seq_pc, br_pc, abs_pc, ind_tgt;
    logic            ind_misal;
    npc_st_t         st_d, st_q;

    assign op = op_e'(op_code);

    npc_cmp #(.XLEN(XLEN)) u_cmp (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .hit (cond_hit)
    );

    npc_tgt #(
        .XLEN(XLEN), .IMM_W(IMM_W), .JIMM_W(JIMM_W), .INSN_BYTES(INSN_BYTES)
    ) u_tgt (
        .pc     (cur_pc),
        .imm16  (imm16),
        .imm26  (imm26),
        .seq_pc (seq_pc),
        .br_pc  (br_pc),
        .abs_pc (abs_pc)
    );

    // Register-held target: return uses the return-address register.
    assign ind_tgt   = (op == OP_RET) ? reg_ra : opnd_a;
    assign ind_misal = |ind_tgt[1:0];

    always_comb begin
        st_d = '0;
        if (op_valid) begin
            st_d.valid = 1'b1;
            st_d.npc   = seq_pc;
            unique case (op)
                OP_SEQ: ;
                OP_BR, OP_BGE, OP_BLT, OP_BNE, OP_BEQ, OP_BGEU, OP_BLTU: begin
                    if (cond_hit) begin
                        st_d.npc   = br_pc;
                        st_d.taken = 1'b1;
                    end
                end
                OP_JABS, OP_CALL: begin
                    st_d.npc   = abs_pc;
                    st_d.taken = 1'b1;
                    if (op == OP_CALL) begin
                        st_d.we    = 1'b1;
                        st_d.idx   = LINK_IDX;
                        st_d.ldata = seq_pc;
                    end
                end
                OP_JREG, OP_CALLR, OP_RET: begin
                    if (ind_misal) begin
                        st_d.exc  = 1'b1;
                        st_d.code = EXC_ALIGN;
                        st_d.bad  = ind_tgt;
                    end else begin
                        st_d.npc   = ind_tgt;
                        st_d.taken = 1'b1;
                        if (op == OP_CALLR) begin
                            st_d.we    = 1'b1;
                            st_d.idx   = LINK_IDX;
                            st_d.ldata = seq_pc;
                        end
                    end
                end
                OP_ERET, OP_BRET: begin
                    if (user_mode) begin
                        st_d.exc  = 1'b1;
                        st_d.code = EXC_PRIV;
                    end else begin
                        st_d.taken = 1'b1;
                        st_d.npc   = (op == OP_ERET) ? reg_ea : reg_ba;
                        st_d.stat  = (op == OP_ERET) ? STAT_EXC : STAT_BRK;
                    end
                end
                OP_NEXTPC: begin
                    if (dst_c != '0) begin
                        st_d.we    = 1'b1;
                        st_d.idx   = dst_c;
                        st_d.ldata = seq_pc;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign npc_valid = st_q.valid;
    assign npc       = st_q.npc;
    assign taken     = st_q.taken;
    assign lnk_we    = st_q.we;
    assign lnk_idx   = st_q.idx;
    assign lnk_data  = st_q.ldata;
    assign stat_sel  = st_q.stat;
    assign exc_req   = st_q.exc;
    assign exc_code  = st_q.code;
    assign bad_addr  = st_q.bad;

    // R1: a cycle without an operation leaves every request low.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!npc_valid && !lnk_we && !exc_req && !taken));

    // R2: sequential flow advances one instruction.
    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SEQ) |=> (npc == $past(cur_pc) + XLEN'(INSN_BYTES) && !taken));

    // R5: absolute jump stays in the current region.
    assert_region_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_JABS) |=> (npc[XLEN-1 -: REGION] == $past(cur_pc[XLEN-1 -: REGION])));

    // R8: an exception never redirects nor writes a link.
    assert_exc_no_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (!lnk_we && !taken && exc_code != EXC_NONE));

    // R8: with aligned PC and saved return addresses, next PC stays aligned.
    assert_npc_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        npc_valid |-> (npc[1:0] == 2'b00));

    // R10: a user-mode return is refused with the privilege code.
    assert_user_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && user_mode && (op_code == OP_ERET || op_code == OP_BRET))
        |=> (exc_req && exc_code == EXC_PRIV && stat_sel == STAT_KEEP));

    // R11: register zero is never named as a link destination.
    assert_no_zero_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_we |-> (lnk_idx != '0));
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] cur_pc = '0;
    logic [15:0] imm16 = '0;
    logic [25:0] imm26 = '0;
    logic [4:0]  dst_c = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, reg_ra = '0, reg_ea = '0, reg_ba = '0;
    logic        user_mode = 1'b0;
    logic        npc_valid, taken, lnk_we, exc_req;
    logic [31:0] npc, lnk_data, bad_addr;
    logic [4:0]  lnk_idx;
    logic [1:0]  stat_sel, exc_code;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .cur_pc(cur_pc), .imm16(imm16), .imm26(imm26), .dst_c(dst_c),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .reg_ra(reg_ra), .reg_ea(reg_ea),
        .reg_ba(reg_ba), .user_mode(user_mode), .npc_valid(npc_valid),
        .npc(npc), .taken(taken), .lnk_we(lnk_we), .lnk_idx(lnk_idx),
        .lnk_data(lnk_data), .stat_sel(stat_sel), .exc_req(exc_req),
        .exc_code(exc_code), .bad_addr(bad_addr)
    );

    task automatic cmp(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Present one operation at a falling edge; return at the next falling edge.
    task automatic issue(logic [3:0] op, logic [31:0] pc, logic [15:0] i16,
                         logic [25:0] i26, logic [31:0] a, logic [31:0] b);
        op_code = op; cur_pc = pc; imm16 = i16; imm26 = i26;
        opnd_a = a; opnd_b = b; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_o(string rq, logic [31:0] e_npc, logic e_tk, logic e_we,
                            logic [4:0] e_idx, logic [31:0] e_ld, logic [1:0] e_st,
                            logic e_exc, logic [1:0] e_code, logic [31:0] e_bad);
        cmp(rq, "valid", 32'(npc_valid), 32'd1);
        cmp(rq, "npc", npc, e_npc);
        cmp(rq, "taken", 32'(taken), 32'(e_tk));
        cmp(rq, "lnk_we", 32'(lnk_we), 32'(e_we));
        if (e_we) begin
            cmp(rq, "lnk_idx", 32'(lnk_idx), 32'(e_idx));
            cmp(rq, "lnk_data", lnk_data, e_ld);
        end
        cmp(rq, "stat_sel", 32'(stat_sel), 32'(e_st));
        cmp(rq, "exc_req", 32'(exc_req), 32'(e_exc));
        cmp(rq, "exc_code", 32'(exc_code), 32'(e_code));
        if (e_exc && e_code == 2'd1) cmp(rq, "bad_addr", bad_addr, e_bad);
    endtask

    function automatic logic [31:0] br_target(logic [31:0] pc, logic [15:0] i);
        logic [31:0] d;
        d = {{16{i[15]}}, i};
        d[1:0] = 2'b00;
        return pc + 32'd4 + d;
    endfunction

    function automatic logic cond_true(logic [3:0] op, logic [31:0] a, logic [31:0] b);
        case (op)
            4'd2: return $signed(a) >= $signed(b);
            4'd3: return $signed(a) <  $signed(b);
            4'd4: return a != b;
            4'd5: return a == b;
            4'd6: return a >= b;
            4'd7: return a <  b;
            default: return 1'b1;
        endcase
    endfunction

    task automatic t_reset_r1;
        cmp("R1", "reset valid", 32'(npc_valid), 0);
        cmp("R1", "reset taken", 32'(taken), 0);
        cmp("R1", "reset lnk_we", 32'(lnk_we), 0);
        cmp("R1", "reset exc", {29'd0, exc_req, exc_code}, 0);
        cmp("R1", "reset stat", 32'(stat_sel), 0);
    endtask

    task automatic t_idle_r1;
        issue(4'd9, 32'h0000_1000, 16'h0, 26'h123, 0, 0);
        @(negedge clk);
        cmp("R1", "idle valid", 32'(npc_valid), 0);
        cmp("R1", "idle lnk_we", 32'(lnk_we), 0);
        cmp("R1", "idle taken", 32'(taken), 0);
    endtask

    task automatic t_seq_r2;
        issue(4'd0, 32'h0000_0100, 16'h7FFC, 26'h3FF_FFFF, 32'h1, 32'h2);
        expect_o("R2", 32'h0000_0104, 0, 0, 0, 0, 0, 0, 0, 0);
        issue(4'd0, 32'hFFFF_FFFC, 16'h0, 26'h0, 0, 0);
        expect_o("R2", 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_br_r3;
        issue(4'd1, 32'h0000_2000, 16'h0013, 26'h0, 0, 0);
        expect_o("R3", br_target(32'h2000, 16'h0013), 1, 0, 0, 0, 0, 0, 0, 0);
        issue(4'd1, 32'h0000_2000, 16'hFFF7, 26'h0, 0, 0);
        expect_o("R3", br_target(32'h2000, 16'hFFF7), 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_cond_r4;
        logic [31:0] av [4] = '{32'h8000_0000, 32'h0000_0005, 32'h0000_0005, 32'hFFFF_FFFF};
        logic [31:0] bv [4] = '{32'h0000_0001, 32'h0000_0005, 32'h0000_0007, 32'h0000_0000};
        for (int op = 2; op <= 7; op++) begin
            for (int k = 0; k < 4; k++) begin
                logic hit;
                hit = cond_true(4'(op), av[k], bv[k]);
                issue(4'(op), 32'h0000_4000, 16'h0040, 26'h0, av[k], bv[k]);
                expect_o("R4", hit ? br_target(32'h4000, 16'h0040) : 32'h4004,
                         hit, 0, 0, 0, 0, 0, 0, 0);
            end
        end
    endtask

    task automatic t_jabs_r5;
        issue(4'd8, 32'hA000_0010, 16'h0, 26'h2AB_CDEF, 0, 0);
        expect_o("R5", {4'hA, 26'h2AB_CDEF, 2'b00}, 1, 0, 0, 0, 0, 0, 0, 0);
        issue(4'd8, 32'hFFFF_FFFC, 16'h0, 26'h000_0001, 0, 0);
        expect_o("R5", 32'hF000_0004, 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_call_r6;
        issue(4'd9, 32'h3000_0200, 16'h0, 26'h000_0040, 0, 0);
        expect_o("R6", 32'h3000_0100, 1, 1, 5'd31, 32'h3000_0204, 0, 0, 0, 0);
    endtask

    task automatic t_indirect_r7;
        issue(4'd10, 32'h0000_0800, 16'h0, 26'h0, 32'h0001_2340, 0);
        expect_o("R7", 32'h0001_2340, 1, 0, 0, 0, 0, 0, 0, 0);
        issue(4'd11, 32'h0000_0800, 16'h0, 26'h0, 32'h0005_0000, 0);
        expect_o("R7", 32'h0005_0000, 1, 1, 5'd31, 32'h0000_0804, 0, 0, 0, 0);
        reg_ra = 32'h0000_9990 & ~32'h3;
        issue(4'd12, 32'h0000_0800, 16'h0, 26'h0, 32'h0000_0011, 0);
        expect_o("R7", 32'h0000_9990, 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_misalign_r8;
        issue(4'd10, 32'h0000_0C00, 16'h0, 26'h0, 32'h0000_1002, 0);
        expect_o("R8", 32'h0000_0C04, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_1002);
        issue(4'd11, 32'h0000_0C00, 16'h0, 26'h0, 32'h0000_1001, 0);
        expect_o("R8", 32'h0000_0C04, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_1001);
        reg_ra = 32'h0000_2003;
        issue(4'd12, 32'h0000_0C00, 16'h0, 26'h0, 32'h0000_0040, 0);
        expect_o("R8", 32'h0000_0C04, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_2003);
    endtask

    task automatic t_returns_r9;
        reg_ea = 32'h0000_7770; reg_ba = 32'h0000_8880; user_mode = 1'b0;
        issue(4'd13, 32'h0000_0040, 16'h0, 26'h0, 0, 0);
        expect_o("R9", 32'h0000_7770, 1, 0, 0, 0, 2'd1, 0, 0, 0);
        issue(4'd14, 32'h0000_0040, 16'h0, 26'h0, 0, 0);
        expect_o("R9", 32'h0000_8880, 1, 0, 0, 0, 2'd2, 0, 0, 0);
    endtask

    task automatic t_user_r10;
        user_mode = 1'b1;
        issue(4'd13, 32'h0000_0040, 16'h0, 26'h0, 0, 0);
        expect_o("R10", 32'h0000_0044, 0, 0, 0, 0, 0, 1, 2'd2, 0);
        issue(4'd14, 32'h0000_0040, 16'h0, 26'h0, 0, 0);
        expect_o("R10", 32'h0000_0044, 0, 0, 0, 0, 0, 1, 2'd2, 0);
        user_mode = 1'b0;
    endtask

    task automatic t_nextpc_r11;
        dst_c = 5'd7;
        issue(4'd15, 32'h0000_5550, 16'h0, 26'h0, 0, 0);
        expect_o("R11", 32'h0000_5554, 0, 1, 5'd7, 32'h0000_5554, 0, 0, 0, 0);
        dst_c = 5'd0;
        issue(4'd15, 32'h0000_5550, 16'h0, 26'h0, 0, 0);
        expect_o("R11", 32'h0000_5554, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        @(negedge clk);
        t_seq_r2();
        t_br_r3();
        t_cond_r4();
        t_jabs_r5();
        t_call_r6();
        t_indirect_r7();
        t_misalign_r8();
        t_returns_r9();
        t_user_r10();
        t_nextpc_r11();
        t_idle_r1();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule